// File: doc/BRIEF.md
# Floating-Point Register Stack

This block holds eight 64-bit value registers that hardware manages as a stack. Operands are named by their distance from a rotating top-of-stack pointer: ST(0) is the top entry and ST(i) sits i places below it. A single command port pushes values onto the stack, stores the top entry out, and writes a result back in place. A push can take its value from the command data, from a copy of any ST(i), or from the constant +0.0. A write-back can replace ST(i), or the top entry, and may pop the stack at the same time.

A separate arithmetic unit reads its two operands combinationally through the ST(0) and ST(i) read ports. It then returns its result through the write-back command, with an optional pop. Each entry carries a valid tag. A push onto an entry that is still valid raises a sticky overflow flag. A read of an entry that is not valid raises a sticky underflow flag. Only the initialise command or reset clears the flags.

Top module: `fpstk_unit`

## Requirements
- R1: Reset, and the initialise command (op 3'd1), set the top pointer to 0, clear all eight valid tags and clear both sticky flags. All of these are visible after the next clock edge.
- R2: `st0_data` shows the entry at physical index `top_ptr`. `sti_data` and `sti_valid` show the data and tag of physical entry (`top_ptr` + `cmd_idx`) mod 8. Both follow the inputs combinationally. `tag_vec` bit k is the tag of physical entry k.
- R3: Push-from-data (op 3'd2) first decrements the top pointer modulo 8. It then writes `cmd_data` into the new top entry and sets its tag, so the former ST(i) becomes ST(i+1).
- R4: Push-copy (op 3'd3) pushes the value that ST(`cmd_idx`) held before the push.
- R5: Push-zero (op 3'd4) pushes 64'h0.
- R6: Store (op 3'd5) drives `out_valid` high for exactly one cycle, on the cycle after the command, with `out_data` equal to the ST(0) value seen at the command. The stack is left unchanged. `out_valid` is low at all other times.
- R7: Store-and-pop (op 3'd6) produces the same output as a store. It also clears the tag of the top entry and increments the top pointer modulo 8.
- R8: Write-back (op 3'd7) writes `cmd_data` into ST(`cmd_idx`) and sets its tag. When `cmd_pop` is 1, it then clears the tag of the old top entry and increments the top pointer. With `cmd_idx` = 0 and a pop, the written entry therefore ends up invalid.
- R9: A push whose target entry is already valid sets `ovf_flag`. The value is still written.
- R10: A push-copy whose source is invalid, or a store or store-and-pop whose ST(0) is invalid, sets `unf_flag`. The command otherwise completes as normal.
- R11: When `cmd_valid` is low, or the op is 3'd0, the pointer, tags, data and flags do not change.
- R12: Once set, `ovf_flag` and `unf_flag` stay set until reset or the initialise command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see requirements) |
| cmd_idx | input | 3 | Stack-relative index i of ST(i) |
| cmd_pop | input | 1 | Pop after a write-back |
| cmd_data | input | 64 | Value for push-from-data and write-back |
| st0_data | output | 64 | Current ST(0) value |
| sti_data | output | 64 | Current ST(cmd_idx) value |
| sti_valid | output | 1 | Tag of ST(cmd_idx) |
| out_valid | output | 1 | Store result strobe |
| out_data | output | 64 | Stored ST(0) value |
| top_ptr | output | 3 | Physical index of the top entry |
| tag_vec | output | 8 | Valid tags by physical index |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
The read ports `st0_data`, `sti_data` and `sti_valid` are due in the same cycle as the index. The bench checks them 1 ns after it drives its inputs, which is before the clock edge. Every stack change, flag and store output is due one register later. The bench compares these at the falling edge that follows the rising edge on which the command was taken. A behavioural model, updated only after that rising edge, supplies the expected values for every comparison on every command.

// File: rtl/fpstk_pkg.sv
// Package: shared command codes and default sizes for the register stack.
// Assumes: the op codes listed here are the encoding used at the command port.
package fpstk_pkg;
    localparam int STK_DEPTH = 8;
    localparam int STK_WIDTH = 64;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_INIT      = 3'd1,
        OP_PUSH_MEM  = 3'd2,
        OP_PUSH_REG  = 3'd3,
        OP_PUSH_ZERO = 3'd4,
        OP_STORE     = 3'd5,
        OP_STORE_POP = 3'd6,
        OP_WRITE     = 3'd7
    } stk_op_e;
endpackage

// File: rtl/fpstk_ptr.sv
// Module: top-of-stack pointer. It moves down on a push and up on a pop,
// modulo the depth, and returns to 0 on initialise.
// Assumes: push and pop are never asserted together; DEPTH is a power of two.
module fpstk_ptr #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_init,
    input  logic          do_push,
    input  logic          do_pop,
    output logic [PW-1:0] top_q,
    output logic [PW-1:0] top_dn
);
    // next push slot, one below the current top
    assign top_dn = top_q - PW'(1);

    // pointer register update
    always_ff @(posedge clk) begin
        if (!rst_n || do_init) top_q <= '0;
        else if (do_push)      top_q <= top_dn;
        else if (do_pop)       top_q <= top_q + PW'(1);
    end

    // R1: initialise returns the pointer to zero
    a_r1_init_top: assert property (@(posedge clk) disable iff (!rst_n)
        do_init |=> top_q == '0);
    // R3: a push moves the pointer down by one, wrapping
    a_r3_push_down: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && !do_init) |=> top_q == $past(top_q) - PW'(1));
    // R7: a pop moves the pointer up by one, wrapping
    a_r7_pop_up: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && !do_init && !do_push) |=> top_q == $past(top_q) + PW'(1));
endmodule

// File: rtl/fpstk_regfile.sv
// Module: data entries with per-entry valid tags and two combinational read
// ports. A clear-all beats a single clear, and a single clear beats a set.
// Assumes: the write and clear addresses are physical indices.
module fpstk_regfile #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 64,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             clr_en,
    input  logic [PW-1:0]    clr_addr,
    input  logic             clr_all,
    input  logic [PW-1:0]    ra_addr,
    input  logic [PW-1:0]    rb_addr,
    output logic [WIDTH-1:0] ra_data,
    output logic [WIDTH-1:0] rb_data,
    output logic [DEPTH-1:0] tags
);
    logic [WIDTH-1:0] mem [DEPTH];

    // entry data storage
    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (!rst_n) mem[k] <= '0;
            else if (wr_en && wr_addr == PW'(k)) mem[k] <= wr_data;
        end
    end

    // valid tag per entry, built by generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_tag
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)                  tags[g] <= 1'b0;
            else if (clr_en && clr_addr == PW'(g))  tags[g] <= 1'b0;
            else if (wr_en && wr_addr == PW'(g))    tags[g] <= 1'b1;
        end
    end

    // combinational read ports
    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];

    // R1: clear-all empties every tag
    a_r1_tags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> tags == '0);
    // R3: a write that is not overridden marks its entry valid
    a_r3_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all && !(clr_en && clr_addr == wr_addr)) |=> tags[$past(wr_addr)]);
    // R7: a single clear leaves its entry invalid
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !tags[$past(clr_addr)]);
endmodule

// File: rtl/fpstk_flags.sv
// Module: sticky overflow and underflow flags.
// Assumes: clear has priority over set in the same cycle.
module fpstk_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ovf_set,
    input  logic unf_set,
    output logic ovf_q,
    output logic unf_q
);
    // flag registers
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_q | ovf_set;
            unf_q <= unf_q | unf_set;
        end
    end

    // R12: overflow stays set until cleared
    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> ovf_q);
    // R12: underflow stays set until cleared
    a_r12_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !clr) |=> unf_q);
    // R9: an overflow event raises the flag
    a_r9_ovf_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_set && !clr) |=> ovf_q);
    // R1: clear drops both flags
    a_r1_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !ovf_q && !unf_q);
endmodule

// File: rtl/fpstk_unit.sv
// Module: top of the floating-point register stack. It decodes commands into
// pointer moves, entry writes and tag clears, and registers the store output.
// Assumes: one command per cycle; ST(i) is the physical entry (top + i) mod DEPTH.
module fpstk_unit
    import fpstk_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH,
    parameter int WIDTH = STK_WIDTH,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [PW-1:0]    cmd_idx,
    input  logic             cmd_pop,
    input  logic [WIDTH-1:0] cmd_data,
    output logic [WIDTH-1:0] st0_data,
    output logic [WIDTH-1:0] sti_data,
    output logic             sti_valid,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic [PW-1:0]    top_ptr,
    output logic [DEPTH-1:0] tag_vec,
    output logic             ovf_flag,
    output logic             unf_flag
);
    stk_op_e          op;
    logic [PW-1:0]    top_q, top_dn, sel_addr, wr_addr;
    logic [WIDTH-1:0] wr_data, ra_data, rb_data;
    logic             do_init, do_push, do_pop, do_store, wr_en, ovf_set, unf_set;
    logic [DEPTH-1:0] tags;

    assign op       = stk_op_e'(cmd_op);
    assign sel_addr = top_q + cmd_idx;

    // command decode into datapath controls
    always_comb begin
        do_init  = cmd_valid && op == OP_INIT;
        do_push  = cmd_valid && (op == OP_PUSH_MEM || op == OP_PUSH_REG || op == OP_PUSH_ZERO);
        do_store = cmd_valid && (op == OP_STORE || op == OP_STORE_POP);
        do_pop   = cmd_valid && (op == OP_STORE_POP || (op == OP_WRITE && cmd_pop));
        wr_en    = do_push || (cmd_valid && op == OP_WRITE);
        wr_addr  = do_push ? top_dn : sel_addr;
        case (op)
            OP_PUSH_REG:  wr_data = rb_data;
            OP_PUSH_ZERO: wr_data = '0;
            default:      wr_data = cmd_data;
        endcase
        ovf_set  = do_push && tags[top_dn];
        unf_set  = (cmd_valid && op == OP_PUSH_REG && !tags[sel_addr]) ||
                   (do_store && !tags[top_q]);
    end

    fpstk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .do_init(do_init), .do_push(do_push),
        .do_pop(do_pop), .top_q(top_q), .top_dn(top_dn)
    );

    fpstk_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clr_en(do_pop), .clr_addr(top_q), .clr_all(do_init),
        .ra_addr(top_q), .rb_addr(sel_addr), .ra_data(ra_data), .rb_data(rb_data),
        .tags(tags)
    );

    fpstk_flags u_flags (
        .clk(clk), .rst_n(rst_n), .clr(do_init), .ovf_set(ovf_set),
        .unf_set(unf_set), .ovf_q(ovf_flag), .unf_q(unf_flag)
    );

    // registered store output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= do_store;
            if (do_store) out_data <= ra_data;
        end
    end

    assign st0_data  = ra_data;
    assign sti_data  = rb_data;
    assign sti_valid = tags[sel_addr];
    assign top_ptr   = top_q;
    assign tag_vec   = tags;

    // R6: a store strobe follows only a store command
    a_r6_out_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(cmd_valid) && ($past(cmd_op) == 3'd5 || $past(cmd_op) == 3'd6));
    // R6: the stored value is the top entry seen at the command
    a_r6_out_value: assert property (@(posedge clk) disable iff (!rst_n)
        do_store |=> out_data == $past(st0_data));
    // R11: an idle cycle leaves the stack untouched
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(top_ptr) && $stable(tag_vec));
    // R5: push-zero puts zero on top
    a_r5_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4) |=> st0_data == '0);
endmodule

// File: tb/fpstk_unit_tb.sv
// Bench: a behavioural model of the stack, compared with the design after every command.
module fpstk_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [2:0]  cmd_idx = 3'd0;
    logic        cmd_pop = 1'b0;
    logic [63:0] cmd_data = 64'h0;
    logic [63:0] st0_data, sti_data, out_data;
    logic        sti_valid, out_valid, ovf_flag, unf_flag;
    logic [2:0]  top_ptr;
    logic [7:0]  tag_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_reg [8];
    bit          m_tag [8];
    int          m_top;
    bit          m_ovf, m_unf, m_ov;
    logic [63:0] m_out;

    fpstk_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_pop(cmd_pop), .cmd_data(cmd_data),
        .st0_data(st0_data), .sti_data(sti_data), .sti_valid(sti_valid),
        .out_valid(out_valid), .out_data(out_data), .top_ptr(top_ptr),
        .tag_vec(tag_vec), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    always #5 clk = ~clk;

    task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", r, what, act, exp);
        end
    endtask

    function automatic logic [7:0] m_tags();
        logic [7:0] v;
        for (int k = 0; k < 8; k++) v[k] = m_tag[k];
        return v;
    endfunction

    task automatic cmp_state(string r);
        chk(r, "top_ptr", 64'(top_ptr), 64'(m_top));
        chk(r, "tag_vec", 64'(tag_vec), 64'(m_tags()));
        chk(r, "ovf_flag", 64'(ovf_flag), 64'(m_ovf));
        chk(r, "unf_flag", 64'(unf_flag), 64'(m_unf));
        chk(r, "out_valid", 64'(out_valid), 64'(m_ov));
        if (m_ov) chk(r, "out_data", out_data, m_out);
    endtask

    // one command: drive at a falling edge, check reads, model the edge, check state
    task automatic step(bit v, logic [2:0] op, logic [2:0] idx, bit pop,
                        logic [63:0] d, string r);
        int src, nt, p;
        logic [63:0] val;
        cmd_valid = v; cmd_op = op; cmd_idx = idx; cmd_pop = pop; cmd_data = d;
        #1;
        src = (m_top + int'(idx)) % 8;
        chk("R2", "st0_data", st0_data, m_reg[m_top]);
        chk("R2", "sti_data", sti_data, m_reg[src]);
        chk("R2", "sti_valid", 64'(sti_valid), 64'(m_tag[src]));
        @(posedge clk);
        #1;
        m_ov = 0;
        if (v) begin
            case (op)
                3'd1: begin
                    m_top = 0; m_ovf = 0; m_unf = 0;
                    for (int k = 0; k < 8; k++) m_tag[k] = 0;
                end
                3'd2, 3'd3, 3'd4: begin
                    val = (op == 3'd2) ? d : (op == 3'd3) ? m_reg[src] : 64'h0;
                    if (op == 3'd3 && !m_tag[src]) m_unf = 1;
                    nt = (m_top + 7) % 8;
                    if (m_tag[nt]) m_ovf = 1;
                    m_reg[nt] = val; m_tag[nt] = 1; m_top = nt;
                end
                3'd5, 3'd6: begin
                    m_ov = 1; m_out = m_reg[m_top];
                    if (!m_tag[m_top]) m_unf = 1;
                    if (op == 3'd6) begin
                        m_tag[m_top] = 0; m_top = (m_top + 1) % 8;
                    end
                end
                3'd7: begin
                    p = src; m_reg[p] = d; m_tag[p] = 1;
                    if (pop) begin
                        m_tag[m_top] = 0; m_top = (m_top + 1) % 8;
                    end
                end
                default: ;
            endcase
        end
        @(negedge clk);
        cmp_state(r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) begin m_reg[k] = 64'h0; m_tag[k] = 0; end
        m_top = 0; m_ovf = 0; m_unf = 0; m_ov = 0; m_out = 64'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_state("R1");
        // pushes from data, wrapping the pointer from 0 to 7
        step(1, 3'd2, 3'd0, 0, 64'h4000_0000_0000_0000, "R3");
        step(1, 3'd2, 3'd0, 0, 64'h4008_0000_0000_0000, "R3");
        step(1, 3'd2, 3'd0, 0, 64'hC010_0000_0000_0000, "R3");
        step(1, 3'd4, 3'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
        step(1, 3'd3, 3'd2, 0, 64'h0, "R4");
        // index sweep with no-op commands
        for (int i = 0; i < 8; i++) step(1, 3'd0, 3'(i), 0, 64'h1234, "R11");
        step(1, 3'd5, 3'd0, 0, 64'h0, "R6");
        step(1, 3'd6, 3'd0, 0, 64'h0, "R7");
        step(1, 3'd7, 3'd1, 0, 64'h3FF0_0000_0000_0000, "R8");
        step(1, 3'd7, 3'd0, 1, 64'hBFF0_0000_0000_0000, "R8");
        step(1, 3'd7, 3'd2, 1, 64'h4014_0000_0000_0000, "R8");
        // fill past full to raise overflow
        for (int i = 0; i < 9; i++) step(1, 3'd2, 3'd0, 0, 64'(i + 100), "R9");
        step(1, 3'd0, 3'd0, 0, 64'h0, "R12");
        step(1, 3'd5, 3'd3, 0, 64'h0, "R12");
        step(1, 3'd1, 3'd0, 0, 64'h0, "R1");
        // empty-stack reads raise underflow
        step(1, 3'd5, 3'd0, 0, 64'h0, "R10");
        step(1, 3'd3, 3'd3, 0, 64'h0, "R10");
        step(0, 3'd2, 3'd1, 0, 64'hDEAD_BEEF, "R11");
        step(0, 3'd6, 3'd0, 0, 64'h0, "R11");
        step(1, 3'd1, 3'd0, 0, 64'h0, "R1");
        step(1, 3'd6, 3'd0, 0, 64'h0, "R10");
        step(1, 3'd2, 3'd5, 0, 64'h7FF0_0000_0000_0000, "R3");
        step(1, 3'd0, 3'd0, 0, 64'h0, "R12");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule